// File: doc/BRIEF.md
# Host Port Attach and Bus Reset Sequencer

This block runs the bring-up of a downstream port on a full/low-speed serial bus host. Once host operation is enabled it turns on the line pull-downs and then waits for a device to appear. A device shows up as the idle line leaving the single-ended-zero condition (both data lines low). It then waits a settling interval and reads the idle state to decide whether the device is full or low speed. After that it drives bus reset for a fixed time, releases it, starts frame generation so the device stays awake, and waits a recovery interval. Only then does it flag the port as ready for enumeration.

Every interval is counted in ticks of an external one-millisecond strobe. The frame timer runs on the block clock, which is taken to be the 12 MHz bit-rate clock. Whenever the line falls back to both-low during a wait or after the port is ready, the block treats this as a disconnect and returns to waiting for an attach. Dropping the host enable returns the block to its off state at any time.

Top module: `hport_attach_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, every output is 0.
- R2: One cycle after `host_en` goes high, `pulldn_en` is 1. One cycle after `host_en` is low, `pulldn_en`, `attach_flag`, `bus_reset`, `sof_en`, `low_speed` and `port_ready` are all 0.
- R3: While waiting for a device, a change of the sampled line from both-low ({dp,dm}=00) to any other value sets `attach_flag`. It stays 1 until a disconnect or host disable.
- R4: After an attach, `bus_reset` stays 0 for SETTLE_MS - 1 ticks of `ms_tick`. It rises on the SETTLE_MS-th tick.
- R5: At the end of the settle interval `low_speed` takes the inverse of `dp` (dp=0 with dm=1 marks a low-speed idle state). It holds that value until a disconnect or host disable.
- R6: `bus_reset` stays 1 for RESET_MS ticks and falls on the RESET_MS-th tick. The line is not checked for disconnect while reset is driven.
- R7: `sof_en` rises on the same edge where `bus_reset` falls. It stays 1 through recovery and while the port is ready. It is never 1 together with `bus_reset`.
- R8: `port_ready` rises on the RECOVER_MS-th tick after `bus_reset` falls, and not before.
- R9: A sampled line of {dp,dm}=00 during the settle wait, the recovery wait or the ready state clears `attach_flag`, `low_speed`, `sof_en` and `port_ready`. The block then needs a fresh attach, and the settle count restarts from zero.
- R10: While `sof_en` is 1, `sof_strobe` pulses high for one cycle every FRAME_CYCLES clocks. The frame counter reloads FRAME_CYCLES each frame. With `sof_en` 0 there is no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, taken as the 12 MHz bit clock |
| rst | input | 1 | Synchronous active-high reset |
| host_en | input | 1 | Enables host port operation |
| dp | input | 1 | Synchronized D+ line level |
| dm | input | 1 | Synchronized D- line level |
| ms_tick | input | 1 | One-cycle strobe every millisecond |
| pulldn_en | output | 1 | Enables the D+ and D- pull-downs |
| bus_reset | output | 1 | Drives reset signalling on the bus |
| sof_en | output | 1 | Enables start-of-frame generation |
| sof_strobe | output | 1 | One-cycle frame start pulse |
| low_speed | output | 1 | Attached device is low speed |
| attach_flag | output | 1 | Device attach detected |
| port_ready | output | 1 | Port ready for enumeration |

## Verification
The assertions assume that `dp` and `dm` are already synchronized to `clk`. They also assume `ms_tick` is a single-cycle pulse, and that the line does not sit at both-low while reset is being driven except through host signalling. The bench drives every input on the falling clock edge. It separates `ms_tick` pulses by an idle cycle. It holds the line at a steady idle level through each reset and recovery interval, so that a both-low sample appears only where a test deliberately makes a disconnect.

// File: rtl/hport_pkg.sv
package hport_pkg;
  typedef enum logic [2:0] {
    PS_OFF,
    PS_WAIT,
    PS_SETTLE,
    PS_RESET,
    PS_RECOVER,
    PS_READY
  } port_state_t;
endpackage

// File: rtl/hport_line_mon.sv
module hport_line_mon (
  input  logic clk,
  input  logic rst,
  input  logic dp,
  input  logic dm,
  output logic se0,
  output logic attach_evt,
  output logic dp_now
);
  logic [1:0] cur_q;
  logic [1:0] prv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= 2'b00;
      prv_q <= 2'b00;
    end else begin
      cur_q <= {dp, dm};
      prv_q <= cur_q;
    end
  end

  assign se0        = (cur_q == 2'b00);
  assign attach_evt = (prv_q == 2'b00) && (cur_q != 2'b00);
  assign dp_now     = cur_q[1];
endmodule

// File: rtl/hport_ms_timer.sv
module hport_ms_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  assign expire = tick && (cnt_q == limit_i - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (tick)  cnt_q <= cnt_q + CNT_W'(1);
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q < limit_i);
endmodule

// File: rtl/hport_frame_timer.sv
module hport_frame_timer #(
  parameter int FRAME_CYCLES = 12000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic strobe
);
  localparam int FC_W = $clog2(FRAME_CYCLES + 1);
  logic [FC_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q  <= FC_W'(FRAME_CYCLES);
      strobe <= 1'b0;
    end else if (cnt_q == FC_W'(1)) begin
      cnt_q  <= FC_W'(FRAME_CYCLES);
      strobe <= 1'b1;
    end else begin
      cnt_q  <= cnt_q - FC_W'(1);
      strobe <= 1'b0;
    end
  end

  // R10
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe);
  // R10
  strobe_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !$past(en)) |-> !strobe);
endmodule

// File: rtl/hport_attach_seq.sv
module hport_attach_seq
  import hport_pkg::*;
#(
  parameter int SETTLE_MS    = 100,
  parameter int RESET_MS     = 50,
  parameter int RECOVER_MS   = 10,
  parameter int FRAME_CYCLES = 12000
) (
  input  logic clk,
  input  logic rst,
  input  logic host_en,
  input  logic dp,
  input  logic dm,
  input  logic ms_tick,
  output logic pulldn_en,
  output logic bus_reset,
  output logic sof_en,
  output logic sof_strobe,
  output logic low_speed,
  output logic attach_flag,
  output logic port_ready
);
  localparam int MAX_A  = (SETTLE_MS > RESET_MS) ? SETTLE_MS : RESET_MS;
  localparam int MAX_MS = (MAX_A > RECOVER_MS) ? MAX_A : RECOVER_MS;
  localparam int CNT_W  = $clog2(MAX_MS + 1);

  port_state_t      state_q, state_n;
  logic             se0, attach_evt, dp_now;
  logic             expire, timed, clr;
  logic [CNT_W-1:0] limit;

  hport_line_mon u_line (
    .clk(clk), .rst(rst), .dp(dp), .dm(dm),
    .se0(se0), .attach_evt(attach_evt), .dp_now(dp_now)
  );

  always_comb begin
    case (state_q)
      PS_SETTLE:  limit = CNT_W'(SETTLE_MS);
      PS_RESET:   limit = CNT_W'(RESET_MS);
      PS_RECOVER: limit = CNT_W'(RECOVER_MS);
      default:    limit = CNT_W'(1);
    endcase
  end

  assign timed = (state_q == PS_SETTLE) || (state_q == PS_RESET) ||
                 (state_q == PS_RECOVER);
  assign clr   = !timed || (state_n != state_q);

  hport_ms_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .clr(clr), .tick(ms_tick),
    .limit_i(limit), .expire(expire)
  );

  always_comb begin
    state_n = state_q;
    if (!host_en) state_n = PS_OFF;
    else begin
      case (state_q)
        PS_OFF:     state_n = PS_WAIT;
        PS_WAIT:    if (attach_evt) state_n = PS_SETTLE;
        PS_SETTLE:  if (se0) state_n = PS_WAIT;
                    else if (expire) state_n = PS_RESET;
        PS_RESET:   if (expire) state_n = PS_RECOVER;
        PS_RECOVER: if (se0) state_n = PS_WAIT;
                    else if (expire) state_n = PS_READY;
        PS_READY:   if (se0) state_n = PS_WAIT;
        default:    state_n = PS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= PS_OFF;
      pulldn_en   <= 1'b0;
      bus_reset   <= 1'b0;
      sof_en      <= 1'b0;
      port_ready  <= 1'b0;
      attach_flag <= 1'b0;
      low_speed   <= 1'b0;
    end else begin
      state_q     <= state_n;
      pulldn_en   <= (state_n != PS_OFF);
      bus_reset   <= (state_n == PS_RESET);
      sof_en      <= (state_n == PS_RECOVER) || (state_n == PS_READY);
      port_ready  <= (state_n == PS_READY);
      attach_flag <= (state_n != PS_OFF) && (state_n != PS_WAIT);
      if ((state_q == PS_SETTLE) && (state_n == PS_RESET))
        low_speed <= !dp_now;
      else if ((state_n == PS_OFF) || (state_n == PS_WAIT))
        low_speed <= 1'b0;
    end
  end

  hport_frame_timer #(.FRAME_CYCLES(FRAME_CYCLES)) u_frame (
    .clk(clk), .rst(rst), .en(sof_en), .strobe(sof_strobe)
  );

  // R7
  rst_sof_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_reset && sof_en));
  // R8
  ready_sof_chk: assert property (@(posedge clk) disable iff (rst)
    port_ready |-> (sof_en && pulldn_en && attach_flag));
  // R2
  host_off_chk: assert property (@(posedge clk) disable iff (rst)
    !host_en |=> (!pulldn_en && !attach_flag && !port_ready));
  // R3
  reset_after_attach_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_reset) |-> (attach_flag && $past(attach_flag)));
  // R5
  speed_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_reset && $past(bus_reset)) |-> $stable(low_speed));
endmodule

// File: tb/hport_attach_seq_bench.sv
`timescale 1ns/1ps
module hport_attach_seq_bench;
  localparam int SET_MS = 100;
  localparam int RST_MS = 50;
  localparam int REC_MS = 10;
  localparam int FRAME  = 12000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_en = 1'b0, dp = 1'b0, dm = 1'b0, ms_tick = 1'b0;
  logic pulldn_en, bus_reset, sof_en, sof_strobe, low_speed, attach_flag, port_ready;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hport_attach_seq #(.SETTLE_MS(SET_MS), .RESET_MS(RST_MS),
                     .RECOVER_MS(REC_MS), .FRAME_CYCLES(FRAME)) u_hport_attach_seq (
    .clk(clk), .rst(rst), .host_en(host_en), .dp(dp), .dm(dm), .ms_tick(ms_tick),
    .pulldn_en(pulldn_en), .bus_reset(bus_reset), .sof_en(sof_en),
    .sof_strobe(sof_strobe), .low_speed(low_speed), .attach_flag(attach_flag),
    .port_ready(port_ready)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      ms_tick = 1'b1; @(negedge clk);
      ms_tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic line(input logic p, input logic m);
    dp = p; dm = m; cyc(3);
  endtask

  function automatic int outs();
    return {pulldn_en, bus_reset, sof_en, sof_strobe, low_speed, attach_flag, port_ready};
  endfunction

  task automatic t_reset();
    cyc(4);
    chk("R1 outputs in reset", outs(), 0);
    @(negedge clk) rst = 1'b0;
    chk("R1 outputs after reset", outs(), 0);
  endtask

  task automatic t_enable();
    host_en = 1'b1; @(negedge clk);
    chk("R2 pulldn after enable", pulldn_en, 1);
    cyc(2);
    chk("R3 no attach on idle SE0", attach_flag, 0);
  endtask

  task automatic t_attach_run(input logic p, input logic m, input int exp_ls);
    line(1'b0, 1'b0);
    line(p, m);
    chk("R3 attach flag", attach_flag, 1);
    ticks(SET_MS - 1);
    chk("R4 no reset before settle end", bus_reset, 0);
    ticks(1);
    chk("R4 reset starts", bus_reset, 1);
    chk("R5 speed", low_speed, exp_ls);
    ticks(RST_MS - 1);
    chk("R6 reset still driven", bus_reset, 1);
    chk("R7 sof off during reset", sof_en, 0);
    ticks(1);
    chk("R6 reset released", bus_reset, 0);
    chk("R7 sof on after reset", sof_en, 1);
    ticks(REC_MS - 1);
    chk("R8 not ready before recovery", port_ready, 0);
    ticks(1);
    chk("R8 ready", port_ready, 1);
    chk("R7 sof on while ready", sof_en, 1);
    chk("R5 speed held", low_speed, exp_ls);
  endtask

  task automatic t_sof_period();
    int gap = 0, width = 0, guard = 0;
    while (!sof_strobe && guard < FRAME + 10) begin @(negedge clk); guard++; end
    chk("R10 first strobe seen", sof_strobe, 1);
    while (sof_strobe) begin width++; @(negedge clk); end
    chk("R10 strobe width", width, 1);
    gap = 1;
    while (!sof_strobe && gap < FRAME + 10) begin @(negedge clk); gap++; end
    chk("R10 frame period", gap, FRAME);
  endtask

  task automatic t_disc_ready();
    line(1'b0, 1'b0);
    chk("R9 ready cleared", port_ready, 0);
    chk("R9 sof cleared", sof_en, 0);
    chk("R9 attach cleared", attach_flag, 0);
    chk("R9 speed cleared", low_speed, 0);
  endtask

  task automatic t_disc_settle();
    line(1'b1, 1'b0);
    chk("R3 attach before drop", attach_flag, 1);
    ticks(20);
    line(1'b0, 1'b0);
    chk("R9 attach cleared in settle", attach_flag, 0);
    ticks(SET_MS);
    chk("R9 no reset while detached", bus_reset, 0);
    line(1'b1, 1'b0);
    ticks(SET_MS - 1);
    chk("R9 settle count restarted", bus_reset, 0);
    ticks(1);
    chk("R9 reset after full settle", bus_reset, 1);
  endtask

  task automatic t_host_off();
    int seen = 0;
    host_en = 1'b0; @(negedge clk);
    chk("R2 all off after disable", outs(), 0);
    repeat (FRAME + 500) begin @(negedge clk); if (sof_strobe) seen++; end
    chk("R10 no strobe while sof off", seen, 0);
  endtask

  initial begin
    t_reset();
    t_enable();
    t_attach_run(1'b1, 1'b0, 0);
    t_sof_period();
    t_disc_ready();
    t_attach_run(1'b0, 1'b1, 1);
    t_disc_ready();
    t_disc_settle();
    t_host_off();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule